// File: doc/BRIEF.md
# Single/Double NaN Width Converter

This unit changes the width of a floating-point NaN between single precision (32 bits) and double precision (64 bits). The NaN keeps its sign and its payload. On the way it classifies the operand as quiet or signaling and raises an invalid-operation flag for a signaling operand. It can also hand back the canonical default NaN. A narrowed payload can lose all of its set bits. In that case the result is the default NaN, because a zero fraction with an all-ones exponent would read as infinity.

The caller guarantees that every operand is a NaN. A single-precision operand sits in bits 31:0 of the operand bus, and bits 63:32 are then ignored. A single-precision result appears in bits 31:0 with bits 63:32 zero. Two configuration inputs shape the result. One sets which value of the fraction MSB means "signaling". The other forces every result to the default NaN. A third input, a quieting enable, makes a signaling operand come out quiet. Outputs are registered and appear one cycle after a valid strobe.

Top module: `nan_width_cvt`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `res_out` and `invalid_out` become zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `res_out` and `invalid_out` load only when `in_valid` is high and hold their values otherwise.
- R3: With `snan_pol`=0, a NaN whose fraction MSB is 0 is signaling. With `snan_pol`=1, a NaN whose fraction MSB is 1 is signaling. `invalid_out` is 1 exactly for a signaling operand, in every mode.
- R4: With `dir_widen`=1, the result keeps the sign in bit 63 and sets bits 62:52 to ones. Its bits 51:29 carry operand bits 22:0, and bits 28:0 are zero.
- R5: With `dir_widen`=0, bit 31 of the result is the operand sign and bits 30:23 are ones. Bits 22:0 are operand bits 51:29, and bits 63:32 are zero.
- R6: When narrowing leaves bits 22:0 all zero, the result is the single-precision default NaN.
- R7: With `dflt_mode`=1, the result is the default NaN of the target width, and `invalid_out` still follows R3.
- R8: The default NaN has sign 0. With `snan_pol`=0 it is 0x7FC00000 (single) or 0x7FF8000000000000 (double). With `snan_pol`=1 it is 0x7FBFFFFF or 0x7FF7FFFFFFFFFFFF.
- R9: With `quiet_en`=1 and `snan_pol`=0, a signaling operand gets its result fraction MSB set. A quiet operand is not changed by `quiet_en`.
- R10: With `quiet_en`=1 and `snan_pol`=1, a signaling operand yields the default NaN of the target width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| dir_widen | input | 1 | 1: single to double, 0: double to single |
| snan_pol | input | 1 | Fraction-MSB value that marks a signaling NaN |
| dflt_mode | input | 1 | Force the default NaN as result |
| quiet_en | input | 1 | Make a signaling operand come out quiet |
| op_in | input | 64 | NaN operand (single in bits 31:0) |
| out_valid | output | 1 | Result strobe |
| res_out | output | 64 | Converted NaN (single in bits 31:0) |
| invalid_out | output | 1 | Operand was a signaling NaN |

## Verification
Every result (`res_out`, `invalid_out` and `out_valid`) is due one clock edge after the edge that samples `in_valid`. The bench drives an operand on a falling edge and withdraws the strobe on the next falling edge. It compares the outputs there, half a cycle after the registering edge. On the falling edge after that, it checks that `out_valid` has dropped and that the result held.

// File: rtl/nanx_pkg.sv
package nanx_pkg;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int FRAC_GAP = DP_FRAC - SP_FRAC;
endpackage

// File: rtl/nanx_classify.sv
module nanx_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  pol,
  output logic                  sign,
  output logic [FRAC_W-1:0]     frac,
  output logic                  is_snan
);
  logic exp_ones;
  logic frac_any;

  assign sign     = word[EXP_W+FRAC_W];
  assign frac     = word[FRAC_W-1:0];
  assign exp_ones = &word[FRAC_W +: EXP_W];
  assign frac_any = |word[FRAC_W-1:0];
  // signaling when the top fraction bit matches the configured polarity
  assign is_snan  = exp_ones && frac_any && (word[FRAC_W-1] == pol);
endmodule

// File: rtl/nanx_default.sv
module nanx_default #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  pol,
  output logic [EXP_W+FRAC_W:0] word
);
  localparam logic [FRAC_W-1:0] MSB_ONLY = {1'b1, {(FRAC_W-1){1'b0}}};

  assign word = {1'b0, {EXP_W{1'b1}}, pol ? ~MSB_ONLY : MSB_ONLY};
endmodule

// File: rtl/nanx_assemble.sv
module nanx_assemble #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  sign,
  input  logic [FRAC_W-1:0]     frac,
  input  logic                  src_snan,
  input  logic                  pol,
  input  logic                  quiet_en,
  input  logic                  force_dflt,
  output logic [EXP_W+FRAC_W:0] word
);
  logic [EXP_W+FRAC_W:0] dflt_word;
  logic [FRAC_W-1:0]     qfrac;
  logic                  quieten;

  nanx_default #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
    .pol  (pol),
    .word (dflt_word)
  );

  assign quieten = quiet_en && src_snan;

  always_comb begin
    qfrac = frac;
    if (quieten && !pol) qfrac[FRAC_W-1] = 1'b1;
    if (force_dflt || (quieten && pol))
      word = dflt_word;
    else
      word = {sign, {EXP_W{1'b1}}, qfrac};
  end
endmodule

// File: rtl/nan_width_cvt.sv
module nan_width_cvt
  import nanx_pkg::*;
#(
  parameter int S_EXP  = SP_EXP,
  parameter int S_FRAC = SP_FRAC,
  parameter int D_EXP  = DP_EXP,
  parameter int D_FRAC = DP_FRAC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      dir_widen,
  input  logic                      snan_pol,
  input  logic                      dflt_mode,
  input  logic                      quiet_en,
  input  logic [D_EXP+D_FRAC:0]     op_in,
  output logic                      out_valid,
  output logic [D_EXP+D_FRAC:0]     res_out,
  output logic                      invalid_out
);
  localparam int SW  = 1 + S_EXP + S_FRAC;
  localparam int DW  = 1 + D_EXP + D_FRAC;
  localparam int GAP = D_FRAC - S_FRAC;

  logic              s_sign, d_sign, s_snan, d_snan;
  logic [S_FRAC-1:0] s_frac, n_frac;
  logic [D_FRAC-1:0] d_frac, w_frac;
  logic              n_zero;
  logic [DW-1:0]     wide_word;
  logic [SW-1:0]     narrow_word;
  logic [DW-1:0]     nxt_res;
  logic              nxt_inv;

  nanx_classify #(.EXP_W(S_EXP), .FRAC_W(S_FRAC)) u_cls_s (
    .word (op_in[SW-1:0]), .pol (snan_pol),
    .sign (s_sign), .frac (s_frac), .is_snan (s_snan)
  );

  nanx_classify #(.EXP_W(D_EXP), .FRAC_W(D_FRAC)) u_cls_d (
    .word (op_in), .pol (snan_pol),
    .sign (d_sign), .frac (d_frac), .is_snan (d_snan)
  );

  // payload is kept left-aligned in both widths
  assign w_frac = {s_frac, {GAP{1'b0}}};
  assign n_frac = d_frac[D_FRAC-1 -: S_FRAC];
  assign n_zero = ~|n_frac;

  nanx_assemble #(.EXP_W(D_EXP), .FRAC_W(D_FRAC)) u_asm_w (
    .sign (s_sign), .frac (w_frac), .src_snan (s_snan), .pol (snan_pol),
    .quiet_en (quiet_en), .force_dflt (dflt_mode), .word (wide_word)
  );

  nanx_assemble #(.EXP_W(S_EXP), .FRAC_W(S_FRAC)) u_asm_n (
    .sign (d_sign), .frac (n_frac), .src_snan (d_snan), .pol (snan_pol),
    .quiet_en (quiet_en), .force_dflt (dflt_mode || n_zero), .word (narrow_word)
  );

  always_comb begin
    if (dir_widen) begin
      nxt_res = wide_word;
      nxt_inv = s_snan;
    end else begin
      nxt_res = {{(DW-SW){1'b0}}, narrow_word};
      nxt_inv = d_snan;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      res_out     <= '0;
      invalid_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out     <= nxt_res;
        invalid_out <= nxt_inv;
      end
    end
  end
endmodule

// File: rtl/nan_width_cvt_chk.sv
module nan_width_cvt_chk
  import nanx_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            dir_widen,
  input logic            snan_pol,
  input logic            dflt_mode,
  input logic [DP_W-1:0] op_in,
  input logic            out_valid,
  input logic [DP_W-1:0] res_out,
  input logic            invalid_out
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_result_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_out) && $stable(invalid_out)));

  assert_wide_exp_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir_widen) |=> (&res_out[DP_W-2 -: DP_EXP]));

  assert_narrow_shape_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir_widen) |=>
      (res_out[DP_W-1:SP_W] == '0) && (&res_out[SP_W-2 -: SP_EXP]));

  assert_dp_snan_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir_widen && (&op_in[DP_W-2 -: DP_EXP]) && |op_in[DP_FRAC-1:0]
      && (op_in[DP_FRAC-1] == snan_pol)) |=> invalid_out);

  assert_default_wide_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir_widen && dflt_mode) |=>
      (res_out[DP_W-1] == 1'b0) && (res_out[DP_FRAC-1] != $past(snan_pol)));
endmodule

bind nan_width_cvt nan_width_cvt_chk u_chk (
  .clk (clk), .rst (rst), .in_valid (in_valid), .dir_widen (dir_widen),
  .snan_pol (snan_pol), .dflt_mode (dflt_mode), .op_in (op_in),
  .out_valid (out_valid), .res_out (res_out), .invalid_out (invalid_out)
);

// File: tb/nan_width_cvt_test.sv
module nan_width_cvt_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, dir_widen, snan_pol, dflt_mode, quiet_en;
  logic [63:0] op_in;
  logic        out_valid, invalid_out;
  logic [63:0] res_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nan_width_cvt uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .dir_widen (dir_widen),
    .snan_pol (snan_pol), .dflt_mode (dflt_mode), .quiet_en (quiet_en),
    .op_in (op_in), .out_valid (out_valid), .res_out (res_out),
    .invalid_out (invalid_out)
  );

  // {widen, pol, dflt, quiet, operand, expected result, expected invalid}
  localparam int NV = 15;
  localparam logic [132:0] VEC [NV] = '{
    {4'b1000, 64'h0000_0000_FFC1_2345, 64'hFFF8_2468_A000_0000, 1'b0}, // R4 quiet
    {4'b1000, 64'h0000_0000_7F80_0001, 64'h7FF0_0000_2000_0000, 1'b1}, // R3 snan
    {4'b1001, 64'h0000_0000_7F80_0001, 64'h7FF8_0000_2000_0000, 1'b1}, // R9
    {4'b1100, 64'h0000_0000_7FC0_0000, 64'h7FF8_0000_0000_0000, 1'b1}, // R3 pol1
    {4'b1101, 64'h0000_0000_7FC0_0000, 64'h7FF7_FFFF_FFFF_FFFF, 1'b1}, // R10
    {4'b1101, 64'h0000_0000_7F80_0010, 64'h7FF0_0002_0000_0000, 1'b0}, // R9 quiet kept
    {4'b1010, 64'h0000_0000_FF80_0005, 64'h7FF8_0000_0000_0000, 1'b1}, // R7
    {4'b1000, 64'hDEAD_BEEF_7FC0_0001, 64'h7FF8_0000_2000_0000, 1'b0}, // R4 upper ignored
    {4'b0000, 64'hFFF8_1234_5678_9ABC, 64'h0000_0000_FFC0_91A2, 1'b0}, // R5
    {4'b0000, 64'h7FF0_0000_2000_0000, 64'h0000_0000_7F80_0001, 1'b1}, // R5 snan
    {4'b0000, 64'h7FF0_0000_0000_0001, 64'h0000_0000_7FC0_0000, 1'b1}, // R6
    {4'b0100, 64'h7FF0_0000_0000_0001, 64'h0000_0000_7FBF_FFFF, 1'b0}, // R6 pol1
    {4'b0001, 64'h7FF0_0000_2000_0000, 64'h0000_0000_7FC0_0001, 1'b1}, // R9 narrow
    {4'b0110, 64'h7FF0_0000_2000_0000, 64'h0000_0000_7FBF_FFFF, 1'b0}, // R8 pol1
    {4'b0100, 64'hFFF8_0000_0000_0000, 64'h0000_0000_FFC0_0000, 1'b1}  // R3 narrow
  };
  string vtag [NV] = '{"R4", "R3", "R9", "R3", "R10", "R9", "R7", "R4",
                       "R5", "R5", "R6", "R6", "R9", "R8", "R3"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [132:0] v);
    @(negedge clk);
    {dir_widen, snan_pol, dflt_mode, quiet_en} = v[132:129];
    op_in    = v[128:65];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; dir_widen = 1'b0; snan_pol = 1'b0;
    dflt_mode = 1'b0; quiet_en = 1'b0; op_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {63'b0, out_valid}, 64'd0);
    check("R1", res_out, 64'd0);
    check("R1", {63'b0, invalid_out}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check("R2", {63'b0, out_valid}, 64'd1);
      check(vtag[i], res_out, VEC[i][64:1]);
      check(vtag[i], {63'b0, invalid_out}, {63'b0, VEC[i][0]});
    end

    // R2: no strobe -> valid drops, result holds
    @(negedge clk);
    check("R2", {63'b0, out_valid}, 64'd0);
    check("R2", res_out, 64'h0000_0000_FFC0_0000);
    check("R2", {63'b0, invalid_out}, 64'd1);

    // R2: operand changes without strobe have no effect
    op_in = 64'h7FF0_0000_0000_0001; dir_widen = 1'b1;
    @(negedge clk);
    check("R2", res_out, 64'h0000_0000_FFC0_0000);

    // R8: pol0 default single via dflt_mode
    apply({4'b0010, 64'hFFF8_0000_2000_0000, 64'h0, 1'b0});
    check("R8", res_out, 64'h0000_0000_7FC0_0000);

    // R1: reset while outputs are busy
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", res_out, 64'd0);
    check("R1", {63'b0, out_valid}, 64'd0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule